// File: doc/BRIEF.md
# Configuration Image Validator

This block checks a 32-word, 16-bit configuration image as it streams in, one word per valid cycle with its index. Word 31 carries the check value: it must equal the 16-bit wrapping sum of words 0 to 30. If the image passes, the block produces three kinds of result:

- It writes one packed setting byte per target into a 16-entry target memory. This covers only targets 0 up to the target count held in word 19.
- It presents a disconnect-disable mask.
- It presents the host ID, a host bus configuration byte and an ultra-enable flag.

If the image fails, the block raises a fallback-to-defaults flag and leaves the configuration outputs as they were.

The controller has three states:

- **IDLE**: a `start_i` pulse moves it to COLLECT (transition *begin*) and clears the image-ok status.
- **COLLECT**: incoming words are stored and summed. A further `start_i` returns it to IDLE (transition *abort*). The word with index 31 ends the image. The block leaves for WRITE if the image is accepted and its target count is non-zero (transition *accept*), and for IDLE otherwise (transition *finish*).
- **WRITE**: one target byte is written per cycle. After the last one the block returns to IDLE (transition *drain*).

A one-cycle `done_o` pulse reports completion, and the first write appears in the same cycle as that pulse.

Top module: `cfgimg_validator`

## Requirements
- R1: One cycle after the word with index 31 is accepted in COLLECT, `done_o` is high for exactly one cycle. `image_ok_o` is 1 exactly when word 31 equals the sum of words 0..30, and `use_defaults_o` is its inverse. Both status flags hold until the next completion, except that `image_ok_o` is cleared when a new image begins.
- R2: Each target byte is packed from that target's flag word as follows:
  - flag bits 2:0 (rate) go to byte bits 6:4;
  - flag bit 3 (sync enable) sets byte bit 0;
  - flag bit 5 (wide) sets byte bit 7;
  - all other byte bits are 0.
- R3: For an accepted image, the block writes targets 0..N-1 at consecutive addresses, one per cycle, starting in the `done_o` cycle. N is the low byte of word 19, limited to 16. No write occurs when N is 0.
- R4: For an accepted image, mask bit t is the inverse of the flag-word bit 4 (disconnect enable) of target t when t < N. Mask bit t is 1 when t >= N.
- R5: For an accepted image, `host_id_o` is word 18 bits 3:0. `scsi_conf_o` is built as follows:
  - bits 2:0 are the low three ID bits;
  - bit 5 is word 17 bit 4 (parity check);
  - bit 6 is word 17 bit 6 (bus reset at start-up);
  - all other bits are 0.
- R6: For an accepted image, `ultra_en_o` is `ultra_cap_i` ANDed with word 17 bit 1.
- R7: A rejected image causes no target write. The mask, host ID, configuration byte and ultra flag keep their previous values.
- R8: A `start_i` during COLLECT abandons the image: there is no `done_o` pulse and no write, and the block returns to IDLE.
- R9: A `start_i` during WRITE has no effect, and words offered outside COLLECT are ignored.
- R10: After reset the outputs are:
  - `done_o`, `image_ok_o`, `tgt_we_o` and `ultra_en_o` are 0;
  - `use_defaults_o` is 1;
  - the mask is all ones;
  - the host ID and configuration byte are 0.
- R11: The checksum sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new image (IDLE) or abort (COLLECT) |
| word_valid_i | input | 1 | Image word present |
| word_idx_i | input | 5 | Index of the image word |
| word_i | input | 16 | Image word |
| ultra_cap_i | input | 1 | Ultra speed capability of the host |
| tgt_we_o | output | 1 | Target memory write strobe |
| tgt_addr_o | output | 4 | Target memory address |
| tgt_data_o | output | 8 | Packed target setting byte |
| disc_dsb_o | output | 16 | Disconnect-disable mask, one bit per target |
| host_id_o | output | 4 | Host bus ID |
| scsi_conf_o | output | 8 | Host bus configuration byte |
| ultra_en_o | output | 1 | Ultra speed enabled |
| use_defaults_o | output | 1 | Image rejected, fall back to defaults |
| done_o | output | 1 | One-cycle completion pulse |
| image_ok_o | output | 1 | Last completed image passed its check |

## Verification
The bench sends several kinds of image, each aimed at a different part of the function:

- **Target counts of 16, 5, 0 and 200.** These separate a correct count limit from a missing clamp or an off-by-one in the write range and the mask.
- **Corrupted check word.** This separates a true comparison from one that ignores the check word.
- **Image of large word values.** This tells a 16-bit wrapping sum from a wider one.
- **Flow-control cases:** gaps between words, an abort part-way through an image, stray words in IDLE, and a start pulse during the write burst. These separate correct state transitions from ones that leak partial images or restart early.

Each image is sent with and without ultra capability and with varied adapter bits, so the configuration byte fields are told apart.

// File: rtl/cfgimg_pkg.sv
package cfgimg_pkg;
    localparam int WORD_W    = 16;
    localparam int IDX_W     = 5;
    localparam int FLAG_W    = 6;
    localparam int TGT_SLOTS = 16;

    // word indices the decoder depends on
    localparam int IDX_ADAPTER = 17;
    localparam int IDX_IDREG   = 18;
    localparam int IDX_MAXT    = 19;
    localparam int IDX_SUM     = 31;

    // flag word bits
    localparam int FB_SYNC = 3;
    localparam int FB_DISC = 4;
    localparam int FB_WIDE = 5;

    // adapter control bits
    localparam int AC_ULTRA  = 1;
    localparam int AC_PARITY = 4;
    localparam int AC_BUSRST = 6;

    // output byte bits
    localparam int TB_OFFS   = 0;
    localparam int TB_RATE   = 4;
    localparam int TB_WIDE   = 7;
    localparam int CB_PARITY = 5;
    localparam int CB_BUSRST = 6;

    typedef logic [FLAG_W-1:0] tflags_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_WRITE   = 2'd2
    } vstate_e;
endpackage

// File: rtl/cfgimg_capture.sv
module cfgimg_capture
    import cfgimg_pkg::*;
#(
    parameter int NUM_TGT = TGT_SLOTS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             take_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [WORD_W-1:0]                word_i,
    output logic [WORD_W-1:0]                sum_o,
    output logic [NUM_TGT-1:0][FLAG_W-1:0]   flags_o,
    output logic [WORD_W-1:0]                adapter_o,
    output logic [3:0]                       hostid_o,
    output logic [7:0]                       maxt_o
);
    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] adp_q;
    logic [3:0]        id_q;
    logic [7:0]        maxt_q;

    // running 16-bit wrapping sum of words 0..30
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sum_q <= '0;
        else if (clear_i) sum_q <= '0;
        else if (take_i)  sum_q <= sum_q + word_i;
    end

    // only the bits the decoder needs are kept per target
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_o[t] <= '0;
            else if (take_i && idx_i == IDX_W'(t))
                flags_o[t] <= word_i[FLAG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adp_q  <= '0;
            id_q   <= '0;
            maxt_q <= '0;
        end else if (take_i) begin
            if (idx_i == IDX_W'(IDX_ADAPTER)) adp_q  <= word_i;
            if (idx_i == IDX_W'(IDX_IDREG))   id_q   <= word_i[3:0];
            if (idx_i == IDX_W'(IDX_MAXT))    maxt_q <= word_i[7:0];
        end
    end

    assign sum_o     = sum_q;
    assign adapter_o = adp_q;
    assign hostid_o  = id_q;
    assign maxt_o    = maxt_q;
endmodule

// File: rtl/cfgimg_tgt_enc.sv
module cfgimg_tgt_enc
    import cfgimg_pkg::*;
(
    input  tflags_t    flags_i,
    output logic [7:0] byte_o
);
    always_comb begin
        byte_o                    = '0;
        byte_o[TB_RATE +: 3]      = flags_i[2:0];
        byte_o[TB_OFFS]           = flags_i[FB_SYNC];
        byte_o[TB_WIDE]           = flags_i[FB_WIDE];
    end
endmodule

// File: rtl/cfgimg_validator.sv
module cfgimg_validator
    import cfgimg_pkg::*;
#(
    parameter int NUM_TGT = TGT_SLOTS,
    localparam int TA_W   = $clog2(NUM_TGT),
    localparam int NT_W   = TA_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                word_valid_i,
    input  logic [IDX_W-1:0]    word_idx_i,
    input  logic [WORD_W-1:0]   word_i,
    input  logic                ultra_cap_i,
    output logic                tgt_we_o,
    output logic [TA_W-1:0]     tgt_addr_o,
    output logic [7:0]          tgt_data_o,
    output logic [NUM_TGT-1:0]  disc_dsb_o,
    output logic [3:0]          host_id_o,
    output logic [7:0]          scsi_conf_o,
    output logic                ultra_en_o,
    output logic                use_defaults_o,
    output logic                done_o,
    output logic                image_ok_o
);
    vstate_e state_q, state_d;

    logic [WORD_W-1:0]              cap_sum;
    logic [NUM_TGT-1:0][FLAG_W-1:0] cap_flags;
    logic [WORD_W-1:0]              cap_adp;
    logic [3:0]                     cap_id;
    logic [7:0]                     cap_maxt;

    logic                clear_c, take_c, last_word_c, sum_ok_c;
    logic [NT_W-1:0]     ntarg_c;
    logic [NUM_TGT-1:0]  dis_en_c;
    logic [7:0]          conf_c;

    logic [TA_W-1:0]     wr_q, last_q;
    logic                done_q, ok_q, def_q, ultra_q;
    logic [NUM_TGT-1:0]  mask_q;
    logic [3:0]          host_q;
    logic [7:0]          conf_q;

    // ---- input qualification ----
    assign clear_c     = (state_q == ST_IDLE) && start_i;
    assign take_c      = (state_q == ST_COLLECT) && !start_i && word_valid_i
                         && (word_idx_i != IDX_W'(IDX_SUM));
    assign last_word_c = (state_q == ST_COLLECT) && !start_i && word_valid_i
                         && (word_idx_i == IDX_W'(IDX_SUM));
    assign sum_ok_c    = (cap_sum == word_i);

    cfgimg_capture #(.NUM_TGT(NUM_TGT)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_c),
        .take_i    (take_c),
        .idx_i     (word_idx_i),
        .word_i    (word_i),
        .sum_o     (cap_sum),
        .flags_o   (cap_flags),
        .adapter_o (cap_adp),
        .hostid_o  (cap_id),
        .maxt_o    (cap_maxt)
    );

    // ---- derived fields ----
    always_comb begin
        if ({1'b0, cap_maxt} > 9'(NUM_TGT)) ntarg_c = NT_W'(NUM_TGT);
        else                                ntarg_c = cap_maxt[NT_W-1:0];
    end

    always_comb begin
        for (int t = 0; t < NUM_TGT; t++)
            dis_en_c[t] = cap_flags[t][FB_DISC] && (NT_W'(t) < ntarg_c);
    end

    always_comb begin
        conf_c            = '0;
        conf_c[2:0]       = cap_id[2:0];
        conf_c[CB_PARITY] = cap_adp[AC_PARITY];
        conf_c[CB_BUSRST] = cap_adp[AC_BUSRST];
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_COLLECT;              // begin
            ST_COLLECT: if (start_i) state_d = ST_IDLE;                 // abort
                        else if (last_word_c)
                            state_d = (sum_ok_c && ntarg_c != '0)
                                      ? ST_WRITE : ST_IDLE;             // accept / finish
            ST_WRITE:   if (wr_q == last_q) state_d = ST_IDLE;          // drain
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- registered outputs ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            def_q   <= 1'b1;
            mask_q  <= '1;
            host_q  <= '0;
            conf_q  <= '0;
            ultra_q <= 1'b0;
            wr_q    <= '0;
            last_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (clear_c) ok_q <= 1'b0;
            if (last_word_c) begin
                done_q <= 1'b1;
                ok_q   <= sum_ok_c;
                def_q  <= !sum_ok_c;
                if (sum_ok_c) begin
                    mask_q  <= ~dis_en_c;
                    host_q  <= cap_id;
                    conf_q  <= conf_c;
                    ultra_q <= ultra_cap_i & cap_adp[AC_ULTRA];
                    wr_q    <= '0;
                    last_q  <= TA_W'(ntarg_c - NT_W'(1));
                end
            end else if (state_q == ST_WRITE) begin
                wr_q <= wr_q + 1'b1;
            end
        end
    end

    // ---- write port ----
    assign tgt_we_o   = (state_q == ST_WRITE);
    assign tgt_addr_o = wr_q;

    cfgimg_tgt_enc u_enc (
        .flags_i (cap_flags[wr_q]),
        .byte_o  (tgt_data_o)
    );

    assign disc_dsb_o     = mask_q;
    assign host_id_o      = host_q;
    assign scsi_conf_o    = conf_q;
    assign ultra_en_o     = ultra_q;
    assign use_defaults_o = def_q;
    assign done_o         = done_q;
    assign image_ok_o     = ok_q;

    // ---- assertions ----
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(word_valid_i) && $past(word_idx_i) == IDX_W'(IDX_SUM)));

    p_status_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (use_defaults_o != image_ok_o));

    p_first_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_we_o) |-> (done_o && image_ok_o && tgt_addr_o == '0));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_we_o && $past(tgt_we_o)) |-> (tgt_addr_o == $past(tgt_addr_o) + 1'b1));

    p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !image_ok_o) |-> (!tgt_we_o && $stable(disc_dsb_o)
                                     && $stable(scsi_conf_o) && $stable(host_id_o)));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_COLLECT && $past(start_i)) |-> (!done_o && !tgt_we_o));
endmodule

// File: tb/cfgimg_validator_tb_top.sv
`timescale 1ns/1ps
module cfgimg_validator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [4:0]  word_idx_i = '0;
    logic [15:0] word_i = '0;
    logic        ultra_cap_i = 1'b0;
    logic        tgt_we_o;
    logic [3:0]  tgt_addr_o;
    logic [7:0]  tgt_data_o;
    logic [15:0] disc_dsb_o;
    logic [3:0]  host_id_o;
    logic [7:0]  scsi_conf_o;
    logic        ultra_en_o, use_defaults_o, done_o, image_ok_o;

    always #2.5 clk = ~clk;   // 200 MHz

    cfgimg_validator dut_i (.*);

    int    checks = 0;
    int    fails  = 0;
    string scen   = "R10";
    bit    cmp_en = 1'b0;
    int    cyc    = 0;

    logic [15:0] img [32];

    // ---------------- reference model ----------------
    int          m_state;     // 0 idle, 1 collect, 2 write
    int          m_words [32];
    int          m_sum, m_wr, m_nt;
    bit          m_done, m_ok, m_def, m_ultra;
    logic [15:0] m_mask;
    logic [3:0]  m_host;
    logic [7:0]  m_conf;

    function automatic logic [7:0] enc_tgt(int f);
        int b;
        b = ((f & 7) * 16) + ((f / 8) % 2) + (((f / 32) % 2) * 128);
        return 8'(b);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_sum = 0; m_wr = 0; m_nt = 0;
            m_done = 0; m_ok = 0; m_def = 1; m_ultra = 0;
            m_mask = 16'hFFFF; m_host = 0; m_conf = 0;
        end else begin
            m_done = 0;
            case (m_state)
                0: if (start_i) begin m_state = 1; m_sum = 0; m_ok = 0; end
                1: begin
                    if (start_i) m_state = 0;
                    else if (word_valid_i) begin
                        if (word_idx_i == 5'd31) begin
                            m_done = 1;
                            m_ok   = ((m_sum % 65536) == int'(word_i));
                            m_def  = !m_ok;
                            m_state = 0;
                            if (m_ok) begin
                                int adp, lim;
                                adp = m_words[17];
                                lim = m_words[19] % 256;
                                m_nt = (lim > 16) ? 16 : lim;
                                for (int t = 0; t < 16; t++)
                                    m_mask[t] = !(((m_words[t] / 16) % 2 == 1) && t < lim);
                                m_host = 4'(m_words[18] % 16);
                                m_conf = 8'((m_words[18] % 8) + ((adp / 16) % 2) * 32
                                            + ((adp / 64) % 2) * 64);
                                m_ultra = ultra_cap_i && ((adp / 2) % 2 == 1);
                                m_wr = 0;
                                if (m_nt > 0) m_state = 2;
                            end
                        end else begin
                            m_words[word_idx_i] = int'(word_i);
                            m_sum = m_sum + int'(word_i);
                        end
                    end
                end
                default: begin
                    if (m_wr == m_nt - 1) m_state = 0;
                    else m_wr = m_wr + 1;
                end
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) at cycle %0d: actual=%0h expected=%0h", tag, scen, cyc, act, exp);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R1 done",       32'(done_o),         32'(m_done));
            chk("R1 image_ok",   32'(image_ok_o),     32'(m_ok));
            chk("R1 defaults",   32'(use_defaults_o), 32'(m_def));
            chk("R4 mask",       32'(disc_dsb_o),     32'(m_mask));
            chk("R5 host_id",    32'(host_id_o),      32'(m_host));
            chk("R5 conf",       32'(scsi_conf_o),    32'(m_conf));
            chk("R6 ultra",      32'(ultra_en_o),     32'(m_ultra));
            chk("R3 write_en",   32'(tgt_we_o),       32'(m_state == 2));
            if (m_state == 2) begin
                chk("R3 addr",   32'(tgt_addr_o),     32'(m_wr));
                chk("R2 data",   32'(tgt_data_o),     32'(enc_tgt(m_words[m_wr])));
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000) begin
            fails++; checks++;
            $display("FAIL watchdog expired (%s)", scen);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic void build(int seed, int maxt, int adp, bit big);
        logic [31:0] x;
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < 31; i++) begin
            x = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h85EBCA6B;
            img[i] = big ? (16'hF000 | x[19:8]) : x[23:8];
        end
        img[17] = 16'(adp);
        img[19] = {img[19][15:8], 8'(maxt)};
        for (int i = 0; i < 31; i++) s = s + img[i];
        img[31] = s;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic send_words(int upto, bit gaps);
        for (int i = 0; i < upto; i++) begin
            @(negedge clk);
            word_valid_i = 1'b1; word_idx_i = 5'(i); word_i = img[i];
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk); word_valid_i = 1'b0;
            end
        end
        @(negedge clk); word_valid_i = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_image(int seed, int maxt, int adp, bit cap, bit gaps, bit big, bit bad);
        build(seed, maxt, adp, big);
        if (bad) img[31] = img[31] ^ 16'h0001;
        ultra_cap_i = cap;
        pulse_start();
        send_words(32, gaps);
        idle(20);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: reset values
        scen = "R10";
        chk("R10 done",     32'(done_o),         32'd0);
        chk("R10 ok",       32'(image_ok_o),     32'd0);
        chk("R10 defaults", 32'(use_defaults_o), 32'd1);
        chk("R10 mask",     32'(disc_dsb_o),     32'hFFFF);
        chk("R10 conf",     32'(scsi_conf_o),    32'd0);
        chk("R10 we",       32'(tgt_we_o),       32'd0);
        cmp_en = 1'b1;
        idle(2);

        scen = "R2 R3 R4 R5 R6 full image";
        run_image(1, 16, 16'h0052, 1'b1, 1'b0, 1'b0, 1'b0);
        scen = "R3 R4 five targets with gaps";
        run_image(2, 5, 16'h0012, 1'b1, 1'b1, 1'b0, 1'b0);
        scen = "R3 zero targets";
        run_image(3, 0, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b0);
        scen = "R3 R6 count clamp no ultra cap";
        run_image(4, 200, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0);
        scen = "R7 R1 corrupted check word";
        run_image(5, 16, 16'h0050, 1'b1, 1'b0, 1'b0, 1'b1);
        scen = "R11 wrapping sum";
        run_image(6, 12, 16'h0046, 1'b1, 1'b1, 1'b1, 1'b0);

        // R8: abort part-way, then R9: stray words in IDLE
        scen = "R8 abort";
        build(7, 9, 16'h0010, 1'b0);
        pulse_start();
        send_words(10, 1'b0);
        pulse_start();
        idle(3);
        scen = "R9 stray words in idle";
        send_words(32, 1'b0);
        idle(5);
        scen = "R8 image after abort";
        run_image(8, 7, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0);

        // R9: start during write burst ignored
        scen = "R9 start during writes";
        build(9, 16, 16'h0052, 1'b0);
        pulse_start();
        send_words(32, 1'b0);   // returns 1 cycle after the last word
        idle(2);
        pulse_start();
        idle(25);
        scen = "R1 image after ignored start";
        run_image(10, 3, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule